// File: doc/BRIEF.md
# Alarm-Signal and Test-Sequence Pattern Detector

This block watches a single recovered receive bit stream, one bit per rising edge of the receive clock, and drives one pattern-detect output. A static mode input selects its function. In alarm mode (the default, mode input low) it counts zeros in consecutive, non-overlapping 2048-bit blocks and raises the output for an all-ones alarm signal. The set and clear thresholds are separated so that a marginal block does not make the output toggle.

In test-pattern mode (mode input high) it locks onto a 2^20-1 quasi-random sequence with 14-zero suppression. It seeds a local generator from the line, predicts every following bit and compares it with the received bit. The output stays high while the block is out of sync. Once locked, the output is low except for a half-clock pulse on every mismatched bit, so an external counter can count bit errors. A loopback indication input is accepted but does not affect detection.

Top module: `pattern_detect`

## Requirements
- R1: After reset with the mode input low (alarm mode), the output is low. Alarm mode is mode input = 0 and test-pattern mode is mode input = 1.
- R2: In alarm mode, a 2048-bit block that holds fewer than 3 zeros sets the output high on the clock edge that takes in the block's last bit.
- R3: In alarm mode, a block that holds more than 3 zeros sets the output low on the edge that takes in the block's last bit.
- R4: In alarm mode, a block with exactly 3 zeros leaves the output unchanged, and the output never changes in the middle of a block.
- R5: The loopback input has no effect on the output in either mode.
- R6: In test-pattern mode, the first 20 received bits seed the generator. The next 128 bits form a hunt interval. If that interval holds fewer than 4 mismatches, the output goes low on the edge of its 128th bit (the 148th bit after the mode change). Until then the output is high.
- R7: While locked, the 4th mismatch within one 128-bit interval (intervals counted from the lock edge) drops sync. The output goes high on that edge and stays high until a new seed and hunt succeed.
- R8: While locked, each mismatched bit drives the output high from the rising edge that samples it until the next falling edge. Fewer than 4 mismatches per interval keep the lock.
- R9: The prediction is raw(n) = raw(n-17) XOR raw(n-20), and it is forced to 1 when the previous 14 predicted bits were all zero. A clean stream from this generator, including its forced ones, produces no error pulse.
- R10: A change of the mode input clears all counters and drops sync on the next rising edge; the received bit on that edge is discarded. After that edge the output is high in test-pattern mode and low in alarm mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; data sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_bit | input | 1 | Recovered receive data bit |
| qrss_mode | input | 1 | 0 = alarm detection, 1 = test-pattern detection |
| loopback_en | input | 1 | Loopback indication, no effect on detection |
| pat_det | output | 1 | Pattern-detect output |

## Verification
The bench builds the block with its default parameters: 2048-bit alarm blocks, a 128-bit sync interval with a limit of 4 errors, a degree-20 generator with its tap at 17, and 14-zero suppression. At these sizes a dozen alarm blocks and several sync intervals fit easily in one run. Seeding the reference generator with all ones brings a run of 17 raw zeros into the first hunt interval, so the forced-one rule affects the lock and the later clean stretch. The tests also place 3 and 4 errors inside a single interval whose alignment is known, which checks both sides of the error limit.

// File: rtl/pd_pkg.sv
package pd_pkg;
    typedef enum logic [1:0] {
        QS_SEED = 2'd0,
        QS_HUNT = 2'd1,
        QS_LOCK = 2'd2
    } qrss_state_e;
endpackage

// File: rtl/ais_window.sv
// Zero counter over non-overlapping blocks with a hysteresis flag.
module ais_window #(
    parameter int WIN       = 2048,
    parameter int SET_BELOW = 3,
    parameter int CLR_ABOVE = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic rx_bit,
    output logic alarm
);
    localparam int BLK_W = $clog2(WIN);
    localparam int ZCAP  = CLR_ABOVE + 1;
    localparam int ZW    = $clog2(ZCAP + 1);

    typedef struct packed {
        logic [BLK_W-1:0] blk;
        logic [ZW-1:0]    zc;
        logic             flag;
    } ais_t;

    ais_t q, d;
    logic [ZW-1:0] zc_next;
    logic          last;

    always_comb begin
        d       = q;
        zc_next = (q.zc == ZW'(ZCAP)) ? q.zc : q.zc + ZW'(!rx_bit);
        last    = (q.blk == BLK_W'(WIN - 1));
        if (clr) begin
            d = '0;
        end else if (last) begin
            d.blk = '0;
            d.zc  = '0;
            if (zc_next < ZW'(SET_BELOW))
                d.flag = 1'b1;
            else if (zc_next > ZW'(CLR_ABOVE))
                d.flag = 1'b0;
        end else begin
            d.blk = q.blk + BLK_W'(1);
            d.zc  = zc_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign alarm = q.flag;

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !clr && zc_next < ZW'(SET_BELOW)) |=> alarm);
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !clr && zc_next > ZW'(CLR_ABOVE)) |=> !alarm);
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (last && !clr && zc_next >= ZW'(SET_BELOW) && zc_next <= ZW'(CLR_ABOVE)) |=> $stable(alarm));
    p_mid_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!last && !clr) |=> $stable(alarm));
endmodule

// File: rtl/qrss_sync.sv
// Seeds a local generator from the line, compares predictions, tracks sync.
module qrss_sync
    import pd_pkg::*;
#(
    parameter int LEN       = 20,
    parameter int TAP       = 17,
    parameter int ZRUN      = 14,
    parameter int WIN       = 128,
    parameter int ERR_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic rx_bit,
    output logic locked,
    output logic err_strobe
);
    localparam int CNT_MAX = (WIN > LEN) ? WIN : LEN;
    localparam int CNT_W   = $clog2(CNT_MAX);
    localparam int ERR_W   = $clog2(ERR_LIMIT + 1);

    typedef struct packed {
        qrss_state_e      state;
        logic [LEN-1:0]   lfsr;
        logic [ZRUN-1:0]  zhist;
        logic [CNT_W-1:0] bitcnt;
        logic [ERR_W-1:0] errcnt;
    } qs_t;

    qs_t q, d;
    logic raw, pred, mismatch, fail;

    always_comb begin
        d        = q;
        raw      = q.lfsr[TAP-1] ^ q.lfsr[LEN-1];
        pred     = raw | (q.zhist == '0);
        mismatch = rx_bit ^ pred;
        fail     = 1'b0;
        if (clr) begin
            d = '0;
        end else if (q.state == QS_SEED) begin
            d.lfsr   = {q.lfsr[LEN-2:0], rx_bit};
            d.zhist  = {q.zhist[ZRUN-2:0], rx_bit};
            d.bitcnt = q.bitcnt + CNT_W'(1);
            if (q.bitcnt == CNT_W'(LEN - 1)) begin
                d.state  = QS_HUNT;
                d.bitcnt = '0;
                d.errcnt = '0;
            end
        end else begin
            d.lfsr   = {q.lfsr[LEN-2:0], raw};
            d.zhist  = {q.zhist[ZRUN-2:0], pred};
            d.bitcnt = q.bitcnt + CNT_W'(1);
            d.errcnt = q.errcnt + ERR_W'(mismatch);
            fail     = mismatch && (q.errcnt == ERR_W'(ERR_LIMIT - 1));
            if (fail) begin
                d.state  = QS_SEED;
                d.bitcnt = '0;
                d.errcnt = '0;
            end else if (q.bitcnt == CNT_W'(WIN - 1)) begin
                d.state  = QS_LOCK;
                d.bitcnt = '0;
                d.errcnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign locked     = (q.state == QS_LOCK);
    assign err_strobe = locked && mismatch && !clr;

    p_lock_from_hunt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(q.state) == QS_HUNT);
    p_err_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> q.errcnt < ERR_W'(ERR_LIMIT));
    p_drop_on_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !clr && mismatch && q.errcnt == ERR_W'(ERR_LIMIT - 1)) |=> !locked);
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q.state == QS_SEED && q.bitcnt == '0));
endmodule

// File: rtl/pattern_detect.sv
module pattern_detect #(
    parameter int AIS_WIN       = 2048,
    parameter int AIS_SET_BELOW = 3,
    parameter int AIS_CLR_ABOVE = 3,
    parameter int PRBS_LEN      = 20,
    parameter int PRBS_TAP      = 17,
    parameter int ZERO_RUN      = 14,
    parameter int SYNC_WIN      = 128,
    parameter int ERR_LIMIT     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic qrss_mode,
    input  logic loopback_en,
    output logic pat_det
);
    typedef struct packed {
        logic mode;
        logic rise_tog;
    } top_t;

    top_t q, d;
    logic fall_tog_q;
    logic clr, alarm, locked, err_strobe, err_pulse;
    logic unused_loopback;

    // Detection is independent of loopback (R5).
    assign unused_loopback = loopback_en;

    assign clr = (qrss_mode != q.mode);

    ais_window #(
        .WIN(AIS_WIN), .SET_BELOW(AIS_SET_BELOW), .CLR_ABOVE(AIS_CLR_ABOVE)
    ) u_ais (
        .clk(clk), .rst_n(rst_n), .clr(clr), .rx_bit(rx_bit), .alarm(alarm)
    );

    qrss_sync #(
        .LEN(PRBS_LEN), .TAP(PRBS_TAP), .ZRUN(ZERO_RUN),
        .WIN(SYNC_WIN), .ERR_LIMIT(ERR_LIMIT)
    ) u_qrss (
        .clk(clk), .rst_n(rst_n), .clr(clr), .rx_bit(rx_bit),
        .locked(locked), .err_strobe(err_strobe)
    );

    always_comb begin
        d      = q;
        d.mode = qrss_mode;
        if (err_strobe) d.rise_tog = ~q.rise_tog;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Falling-edge follower ends each error pulse half a period later (R8).
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_tog_q <= 1'b0;
        else        fall_tog_q <= q.rise_tog;
    end

    assign err_pulse = q.rise_tog ^ fall_tog_q;
    assign pat_det   = qrss_mode ? (~locked | err_pulse) : alarm;

    p_mode_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!locked && !alarm));
    p_pulse_needs_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rise_tog != $past(q.rise_tog)) |-> $past(locked));
endmodule

// File: tb/pattern_detect_tb.sv
`timescale 1ns/1ps
module pattern_detect_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b0;
    logic qrss_mode = 1'b0;
    logic loopback_en = 1'b0;
    logic pat_det;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic hi_s, lo_s;
    logic [19:0] g;
    logic [13:0] gz;
    int gcnt;
    logic [19:0] gseed;
    logic ais_exp;

    always #2.5 clk = ~clk;

    pattern_detect u_dut (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .qrss_mode(qrss_mode),
        .loopback_en(loopback_en), .pat_det(pat_det)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One bit: drive after falling edge, sample high phase and low phase.
    task automatic step(input logic b);
        rx_bit = b;
        loopback_en = 1'($urandom);
        @(posedge clk); #1 hi_s = pat_det;
        @(negedge clk); #1 lo_s = pat_det;
    endtask

    task automatic set_mode(input logic m);
        qrss_mode = m;
        step(1'b0);
    endtask

    function automatic logic ais_next(input logic cur, input int zeros);
        if (zeros < 3) return 1'b1;
        if (zeros > 3) return 1'b0;
        return cur;
    endfunction

    task automatic gen_init(input logic [19:0] s);
        gseed = s; gcnt = 0; g = '0; gz = '0;
    endtask

    task automatic gen_bit(output logic b);
        logic r;
        if (gcnt < 20) begin
            b = gseed[19 - gcnt];
            g = {g[18:0], b};
            gz = {gz[12:0], b};
        end else begin
            r = g[16] ^ g[19];
            b = r | (gz == '0);
            g = {g[18:0], r};
            gz = {gz[12:0], b};
        end
        gcnt++;
    endtask

    task automatic ais_block(input int k);
        int off;
        bit mid_ok;
        logic prev;
        off = $urandom_range(0, 299);
        prev = ais_exp;
        mid_ok = 1'b1;
        for (int i = 0; i < 2048; i++) begin
            step(!((i >= off) && ((i - off) % 300 == 0) && ((i - off) / 300 < k)));
            if (i < 2047 && (hi_s !== prev)) mid_ok = 1'b0;
        end
        ais_exp = ais_next(prev, k);
        check(mid_ok, "R4 mid-block stable", int'(hi_s), int'(prev));
        if (k < 3)      check(hi_s === ais_exp, "R2 set", int'(hi_s), int'(ais_exp));
        else if (k > 3) check(hi_s === ais_exp, "R3 clear", int'(hi_s), int'(ais_exp));
        else            check(hi_s === ais_exp, "R4 hold", int'(hi_s), int'(ais_exp));
        check(hi_s === ais_exp, "R5 loopback toggling ignored", int'(hi_s), int'(ais_exp));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic b;
        bit ok;
        int lk;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 check(pat_det === 1'b0, "R1 reset state", int'(pat_det), 0);
        @(negedge clk); rst_n = 1'b1; #1;
        check(pat_det === 1'b0, "R1 after reset", int'(pat_det), 0);

        // Alarm mode: directed block zero counts then random ones.
        ais_exp = 1'b0;
        ais_block(0); ais_block(3); ais_block(4); ais_block(3); ais_block(2);
        for (int n = 0; n < 6; n++) ais_block($urandom_range(0, 6));

        // Test-pattern mode.
        set_mode(1'b1);
        check(hi_s === 1'b1, "R10 enter pattern mode high", int'(hi_s), 1);
        gen_init(20'hFFFFF);
        ok = 1'b1;
        for (int i = 1; i <= 148; i++) begin
            gen_bit(b); step(b);
            if (i < 148 && hi_s !== 1'b1) ok = 1'b0;
            if (i == 147) check(hi_s === 1'b1, "R6 high before lock", int'(hi_s), 1);
        end
        check(ok, "R6 high during seed and hunt", 0, 1);
        check(hi_s === 1'b0, "R6 low at 148th bit", int'(hi_s), 0);

        lk = 0;
        ok = 1'b1;
        for (int i = 0; i < 1200; i++) begin
            gen_bit(b); step(b); lk++;
            if (hi_s !== 1'b0 || lo_s !== 1'b0) ok = 1'b0;
        end
        check(ok, "R9 clean stream with forced ones gives no pulse", 1, 0);

        // Three errors in one interval: pulses, lock kept.
        while (lk % 128 != 0) begin gen_bit(b); step(b); lk++; end
        for (int i = 0; i < 128; i++) begin
            gen_bit(b);
            if (i == 10 || i == 40 || i == 70) begin
                step(~b);
                check(hi_s === 1'b1, "R8 pulse in high phase", int'(hi_s), 1);
                check(lo_s === 1'b0, "R8 pulse gone after falling edge", int'(lo_s), 0);
            end else begin
                step(b);
            end
            lk++;
        end
        check(hi_s === 1'b0 && lo_s === 1'b0, "R8 lock kept after 3 errors", int'(hi_s), 0);

        // Four errors in one interval: sync lost.
        for (int i = 0; i < 14; i++) begin
            gen_bit(b);
            if (i >= 10) step(~b); else step(b);
        end
        check(hi_s === 1'b1 && lo_s === 1'b1, "R7 sync lost on 4th error", int'(lo_s), 1);
        ok = 1'b0;
        for (int i = 0; i < 4000 && !ok; i++) begin
            gen_bit(b); step(b);
            if (hi_s === 1'b0) ok = 1'b1;
        end
        check(ok, "R7 relock after reseed", int'(ok), 1);

        // Back to alarm mode.
        set_mode(1'b0);
        check(hi_s === 1'b0, "R10 enter alarm mode low", int'(hi_s), 0);
        ais_exp = 1'b0;
        ais_block(1);
        finish_run();
    end
endmodule